// File: doc/BRIEF.md
# Atomic Word Read-Modify-Write Sequencer

This unit carries out the 32-bit atomic word instructions for a simple in-order core. The core presents a raw instruction word, a base address and the second source operand, and raises `start` for one cycle. The unit decodes the instruction. If the instruction is one of the atomic word forms, the unit drives a single-port, synchronous-read word memory through a short fixed sequence. It then pulses `done` with the value for the destination register. `busy` stays high for the whole sequence so that the core can stall.

There are three kinds of instruction:

- **Read-modify-write operations (nine of them).** The unit reads the old word, computes a new word from the old word and the operand, and writes the new word back. The destination register receives the old word.
- **Load-reserved.** The unit reads a word and records a single reservation on that word address.
- **Store-conditional.** The unit writes only while that reservation is still intact.

The state machine has five named states:

- **IDLE**: waits for an accepted `start`.
- **READ**: read enable is asserted.
- **CAPTURE**: the memory's registered read data is latched.
- **WRITE**: write enable is asserted with the new word.
- **DONE**: a one-cycle `done` pulse is given.

The transitions are:

- IDLE→READ when a load-reserved or read-modify-write instruction is accepted.
- IDLE→WRITE when a store-conditional is accepted and the reservation holds.
- IDLE→DONE when a store-conditional is accepted and the reservation does not hold.
- READ→CAPTURE always.
- CAPTURE→WRITE for a read-modify-write.
- CAPTURE→DONE for a load-reserved.
- WRITE→DONE always.
- DONE→IDLE always.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is acted on only when bits [6:0] are 0101111 and bits [14:12] are 010; any other pattern leaves the unit idle, with `busy` low and no memory strobe.
- R2: Bits [31:27] select the kind: 00010 load-reserved, 00011 store-conditional, 00000 add, 00001 swap, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max; any other value is ignored as in R1.
- R3: Add writes old+operand (modulo 2^32), swap writes the operand, and xor, and, or write the bitwise result of old and operand.
- R4: Signed min and signed max compare old and operand as two's-complement values and write the selected one.
- R5: Unsigned min and unsigned max compare old and operand as unsigned values and write the selected one.
- R6: A read-modify-write asserts read enable in the 1st cycle after acceptance and write enable in the 3rd cycle, both to the same address, and pulses `done` in the 4th cycle; read and write enable are never high together.
- R7: After a read-modify-write, `rd_value` during `done` is the word read before modification.
- R8: Load-reserved reads the word (read in cycle 1, `done` in cycle 3), returns it on `rd_value`, issues no write, and reserves that word address.
- R9: Store-conditional to the reserved word writes the operand in cycle 1, pulses `done` in cycle 2 and returns 0.
- R10: Store-conditional without a matching reservation issues no memory access, pulses `done` in cycle 1 and returns 1. Every store-conditional clears the reservation.
- R11: A read-modify-write to the reserved word clears the reservation, one to another word leaves it, and reset clears it.
- R12: Address bits [1:0] are ignored: memory addresses always have zero low bits and reservation matching uses bits [31:2] only.
- R13: `start` is accepted only in IDLE. `busy` is high from the cycle after acceptance through the `done` cycle and low after it, and a `start` that arrives while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled in IDLE |
| instr | input | 32 | Raw instruction word |
| base_addr | input | ADDR_W | Byte address from the first source register |
| rs2_val | input | DATA_W | Second source operand |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle completion pulse |
| rd_value | output | DATA_W | Destination register value, valid with `done` |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rd_en | output | 1 | Memory read enable (data returns next cycle) |
| mem_wr_en | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, registered in the memory |

## Verification
The assertions check the following on every cycle:

- the read and write enables never overlap;
- a read is followed by a quiet cycle;
- a write is always followed by `done`;
- `done` always ends `busy`;
- the memory address stays fixed and word-aligned for a whole sequence;
- `busy` only rises after a `start`.

The following can only be shown by the bench's scenarios against its own memory model:

- the computed values of the nine operations, including signed and unsigned edges;
- the returned old word;
- the reservation history across load-reserved, store-conditional, other operations and reset;
- the cycle positions of the strobes;
- the rejection of non-atomic encodings.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_LR,
        K_SC,
        K_RMW
    } amo_kind_e;

    typedef enum logic [3:0] {
        F_ADD,
        F_SWAP,
        F_XOR,
        F_AND,
        F_OR,
        F_MIN,
        F_MAX,
        F_MINU,
        F_MAXU
    } amo_fn_e;

    localparam logic [6:0] AMO_MAJOR  = 7'b0101111;
    localparam logic [2:0] AMO_WIDTHW = 3'b010;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [4:0] sel_f5,
    input  logic [2:0] width_f3,
    input  logic [6:0] major_op,
    output amo_kind_e  kind,
    output amo_fn_e    fn
);

    always_comb begin
        kind = K_NONE;
        fn   = F_ADD;
        if (major_op == AMO_MAJOR && width_f3 == AMO_WIDTHW) begin
            case (sel_f5)
                5'b00010: kind = K_LR;
                5'b00011: kind = K_SC;
                5'b00000: begin kind = K_RMW; fn = F_ADD;  end
                5'b00001: begin kind = K_RMW; fn = F_SWAP; end
                5'b00100: begin kind = K_RMW; fn = F_XOR;  end
                5'b01100: begin kind = K_RMW; fn = F_AND;  end
                5'b01000: begin kind = K_RMW; fn = F_OR;   end
                5'b10000: begin kind = K_RMW; fn = F_MIN;  end
                5'b10100: begin kind = K_RMW; fn = F_MAX;  end
                5'b11000: begin kind = K_RMW; fn = F_MINU; end
                5'b11100: begin kind = K_RMW; fn = F_MAXU; end
                default:  kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/amo_opunit.sv
module amo_opunit
    import amo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  amo_fn_e           fn,
    output logic [DATA_W-1:0] result
);

    logic s_lt;
    logic u_lt;

    assign s_lt = $signed(old_val) < $signed(operand);
    assign u_lt = old_val < operand;

    always_comb begin
        unique case (fn)
            F_ADD:   result = old_val + operand;
            F_SWAP:  result = operand;
            F_XOR:   result = old_val ^ operand;
            F_AND:   result = old_val & operand;
            F_OR:    result = old_val | operand;
            F_MIN:   result = s_lt ? old_val : operand;
            F_MAX:   result = s_lt ? operand : old_val;
            F_MINU:  result = u_lt ? old_val : operand;
            F_MAXU:  result = u_lt ? operand : old_val;
            default: result = operand;
        endcase
    end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int WA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [WA_W-1:0] set_addr,
    input  logic            clr_en,
    input  logic [WA_W-1:0] chk_addr,
    output logic            hit
);

    logic            valid_q;
    logic [WA_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (set_en) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr;
        end else if (clr_en) begin
            valid_q <= 1'b0;
        end
    end

    assign hit = valid_q && (addr_q == chk_addr);

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] rs2_val,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_value,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int WA_W = ADDR_W - 2;

    amo_state_e      state_q, state_d;
    amo_kind_e       dec_kind, kind_q;
    amo_fn_e         dec_fn, fn_q;
    logic [WA_W-1:0] req_waddr, waddr_q;
    logic [DATA_W-1:0] rs2_q, old_q, rd_q, op_result;
    logic            accept;
    logic            resv_hit;
    logic            resv_set, resv_clr;
    logic            unused_bits;

    assign unused_bits = ^{instr[26:15], instr[11:7], base_addr[1:0]};
    assign req_waddr   = base_addr[ADDR_W-1:2];

    amo_decode u_dec (
        .sel_f5   (instr[31:27]),
        .width_f3 (instr[14:12]),
        .major_op (instr[6:0]),
        .kind     (dec_kind),
        .fn       (dec_fn)
    );

    amo_opunit #(.DATA_W(DATA_W)) u_op (
        .old_val (old_q),
        .operand (rs2_q),
        .fn      (fn_q),
        .result  (op_result)
    );

    assign accept   = start && (state_q == ST_IDLE) && (dec_kind != K_NONE);
    assign resv_set = (state_q == ST_CAPTURE) && (kind_q == K_LR);
    assign resv_clr = accept && ((dec_kind == K_SC) || ((dec_kind == K_RMW) && resv_hit));

    amo_resv #(.WA_W(WA_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (resv_set),
        .set_addr (waddr_q),
        .clr_en   (resv_clr),
        .chk_addr (req_waddr),
        .hit      (resv_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_kind == K_SC) state_d = resv_hit ? ST_WRITE : ST_DONE;
                    else                  state_d = ST_READ;
                end
            end
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = (kind_q == K_LR) ? ST_DONE : ST_WRITE;
            ST_WRITE:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // request and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_NONE;
            fn_q    <= F_ADD;
            waddr_q <= '0;
            rs2_q   <= '0;
            old_q   <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                kind_q  <= dec_kind;
                fn_q    <= dec_fn;
                waddr_q <= req_waddr;
                rs2_q   <= rs2_val;
                if (dec_kind == K_SC) rd_q <= resv_hit ? DATA_W'(0) : DATA_W'(1);
            end
            if (state_q == ST_CAPTURE) begin
                old_q <= mem_rdata;
                rd_q  <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_READ:    mem_rd_en = 1'b1;
            ST_CAPTURE: ;
            ST_WRITE:   mem_wr_en = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
        busy      = (state_q != ST_IDLE);
        mem_addr  = {waddr_q, 2'b00};
        mem_wdata = (kind_q == K_SC) ? rs2_q : op_result;
        rd_value  = rd_q;
    end

endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr
);

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R6
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en && !mem_wr_en && busy));

    // R6
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> done);

    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R12
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00));

    // R13
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R13
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R13
    done_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind amo_rmw_unit amo_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr)
);

// File: tb/amo_rmw_unit_tb.sv
module amo_rmw_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_addr = '0;
    logic [31:0] rs2_val = '0;
    logic        busy, done, mem_rd_en, mem_wr_en;
    logic [31:0] rd_value, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_m [64];

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    amo_rmw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base_addr(base_addr), .rs2_val(rs2_val), .busy(busy), .done(done),
        .rd_value(rd_value), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata)
    );

    // synchronous-read word memory model
    always @(posedge clk) begin
        if (mem_wr_en) mem_m[mem_addr[7:2]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem_m[mem_addr[7:2]];
    end

    localparam logic [4:0] C_LR = 5'b00010, C_SC = 5'b00011, C_ADD = 5'b00000,
        C_SWAP = 5'b00001, C_XOR = 5'b00100, C_AND = 5'b01100, C_OR = 5'b01000,
        C_MIN = 5'b10000, C_MAX = 5'b10100, C_MINU = 5'b11000, C_MAXU = 5'b11100;

    localparam int NV = 12;
    localparam logic [4:0]  V_F5  [NV] = '{C_ADD, C_SWAP, C_XOR, C_AND, C_OR, C_MIN,
                                           C_MAX, C_MINU, C_MAXU, C_MIN, C_MAXU, C_ADD};
    localparam logic [31:0] V_OLD [NV] = '{32'h0000_0005, 32'h1234_5678, 32'hF0F0_F0F0,
        32'hF0F0_F0F0, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF};
    localparam logic [31:0] V_RS2 [NV] = '{32'hFFFF_FFFE, 32'hCAFE_0001, 32'hFF00_FF00,
        32'hFF00_FF00, 32'h0F00_0F00, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001,
        32'h0000_0001, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_0001};
    localparam logic [31:0] V_NEW [NV] = '{32'h0000_0003, 32'hCAFE_0001, 32'h0FF0_0FF0,
        32'hF000_F000, 32'hFFF0_FFF0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000};

    function automatic logic [31:0] mk(input logic [4:0] f5);
        return {f5, 2'b00, 5'd2, 5'd1, 3'b010, 5'd3, 7'b0101111};
    endfunction

    function automatic string req_of(input logic [4:0] f5);
        if (f5 == C_MIN || f5 == C_MAX) return "R4";
        if (f5 == C_MINU || f5 == C_MAXU) return "R5";
        return "R3";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    int k_rd, k_wr, k_done, n_rd, n_wr;
    bit busy_ok;
    logic [31:0] wr_a, rd_a, got;

    task automatic run_op(input logic [31:0] ins, input logic [31:0] addr,
                          input logic [31:0] rs2);
        k_rd = -1; k_wr = -1; k_done = -1; n_rd = 0; n_wr = 0; busy_ok = 1'b1;
        wr_a = '0; rd_a = '0; got = 'x;
        @(negedge clk);
        instr = ins; base_addr = addr; rs2_val = rs2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            if (!busy) busy_ok = 1'b0;
            if (mem_rd_en) begin n_rd++; k_rd = k; rd_a = mem_addr; end
            if (mem_wr_en) begin n_wr++; k_wr = k; wr_a = mem_addr; end
            if (done) begin got = rd_value; k_done = k; break; end
            @(negedge clk);
        end
    endtask

    // ignored request: watch six cycles for any activity
    task automatic run_ignored(input logic [31:0] ins, input string req);
        int act;
        act = 0;
        @(negedge clk);
        instr = ins; base_addr = 32'h20; rs2_val = 32'h55; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (busy || done || mem_rd_en || mem_wr_en) act++;
            @(negedge clk);
        end
        check(act == 0 && mem_m[8] == 32'h0BAD_0BAD, req, act, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem_m[i] = 32'h0BAD_0BAD;
        repeat (3) @(negedge clk);
        // reset state (R13)
        check(!busy && !done && !mem_rd_en && !mem_wr_en, "R13", {busy, done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;

        // R1: wrong major opcode and doubleword width; R2: unknown selector
        run_ignored(32'h0020_81B3, "R1");
        run_ignored({C_ADD, 2'b00, 5'd2, 5'd1, 3'b011, 5'd3, 7'b0101111}, "R1");
        run_ignored({5'b00101, 2'b00, 5'd2, 5'd1, 3'b010, 5'd3, 7'b0101111}, "R2");

        // operation table: R3/R4/R5 values, R7 old value, R6 timing
        for (int i = 0; i < NV; i++) begin
            mem_m[i + 8] = V_OLD[i];
            run_op(mk(V_F5[i]), 32'(i + 8) << 2, V_RS2[i]);
            check(mem_m[i + 8] == V_NEW[i], req_of(V_F5[i]), mem_m[i + 8], V_NEW[i]);
            check(got == V_OLD[i], "R7", got, V_OLD[i]);
            check(k_rd == 1 && k_wr == 3 && k_done == 4 && n_rd == 1 && n_wr == 1 &&
                  rd_a == wr_a && wr_a == (32'(i + 8) << 2) && busy_ok,
                  "R6", 32'(k_done), 4);
        end

        // R8 load-reserved, then R9 successful store-conditional
        mem_m[40] = 32'hA5A5_0001;
        run_op(mk(C_LR), 32'd160, 32'h0);
        check(got == 32'hA5A5_0001 && n_wr == 0 && k_rd == 1 && k_done == 3, "R8", got, 32'hA5A5_0001);
        run_op(mk(C_SC), 32'd160, 32'h1357_9BDF);
        check(got == 0 && mem_m[40] == 32'h1357_9BDF && k_wr == 1 && k_done == 2 && n_rd == 0,
              "R9", mem_m[40], 32'h1357_9BDF);

        // R10: second store-conditional finds reservation cleared
        run_op(mk(C_SC), 32'd160, 32'hDEAD_0000);
        check(got == 1 && mem_m[40] == 32'h1357_9BDF && n_wr == 0 && n_rd == 0 && k_done == 1,
              "R10", got, 1);

        // R10: store-conditional to a different word fails and still clears
        run_op(mk(C_LR), 32'd160, 32'h0);
        run_op(mk(C_SC), 32'd164, 32'h1111_1111);
        check(got == 1 && n_wr == 0, "R10", got, 1);
        run_op(mk(C_SC), 32'd160, 32'h2222_2222);
        check(got == 1 && mem_m[40] == 32'h1357_9BDF, "R10", got, 1);

        // R11: operation on the reserved word clears it
        run_op(mk(C_LR), 32'd160, 32'h0);
        run_op(mk(C_ADD), 32'd160, 32'h1);
        run_op(mk(C_SC), 32'd160, 32'h3333_3333);
        check(got == 1 && mem_m[40] == 32'h1357_9BE0, "R11", got, 1);

        // R11: operation on another word leaves it
        run_op(mk(C_LR), 32'd160, 32'h0);
        run_op(mk(C_OR), 32'd168, 32'h1);
        run_op(mk(C_SC), 32'd160, 32'h4444_4444);
        check(got == 0 && mem_m[40] == 32'h4444_4444, "R11", got, 0);

        // R11: reset clears it
        run_op(mk(C_LR), 32'd160, 32'h0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        run_op(mk(C_SC), 32'd160, 32'h5555_5555);
        check(got == 1 && mem_m[40] == 32'h4444_4444, "R11", got, 1);

        // R12: low address bits ignored for access and reservation match
        mem_m[44] = 32'h0000_00AB;
        run_op(mk(C_LR), 32'd179, 32'h0);
        check(got == 32'h0000_00AB && rd_a == 32'd176, "R12", rd_a, 32'd176);
        run_op(mk(C_SC), 32'd177, 32'h6666_6666);
        check(got == 0 && wr_a == 32'd176 && mem_m[44] == 32'h6666_6666, "R12", wr_a, 32'd176);

        // R13: start while busy ignored
        mem_m[50] = 32'h10;
        mem_m[51] = 32'h77;
        @(negedge clk);
        instr = mk(C_ADD); base_addr = 32'd200; rs2_val = 32'h5; start = 1'b1;
        @(negedge clk);
        instr = mk(C_SWAP); base_addr = 32'd204; rs2_val = 32'h99;
        begin
            int dones;
            dones = 0;
            for (int k = 0; k < 10; k++) begin
                if (k == 2) start = 1'b0;
                if (done) dones++;
                @(negedge clk);
            end
            start = 1'b0;
            check(dones == 1 && mem_m[51] == 32'h77 && mem_m[50] == 32'h15 && !busy,
                  "R13", mem_m[51], 32'h77);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule